// File: doc/BRIEF.md
# Priority-Ordered Dynamic Frame Packer

This block sits between the message producers of a node and the transmit side of a time-division bus. Producers hand it variable-size outgoing messages, each carrying an urgency level, a length in bytes, an identifier and a small payload. The block keeps them in a queue sorted by urgency. Messages of equal urgency stay in the order they arrived.

When the node's transmit slot comes round, a one-cycle strobe arrives with the usable data-field length of that slot. The block then takes messages from the head of the queue and streams each one out as an identifier header followed by its payload bytes. It stops at the first message whose header and payload would not fit in the space that is left. Messages are never split across frames. The message that did not fit, and everything behind it, stays queued for the next round, even when a smaller message further back would have fitted. After the last byte it raises a single-cycle frame-complete flag. An activation with nothing queued gives an empty frame and still raises the flag.

Top module: `prio_frame_packer`

## Requirements
- R1: A message with a numerically larger `in_prio` is sent before any queued message with a smaller `in_prio`, whatever the order in which they arrived.
- R2: Messages with equal `in_prio` are sent in the order they were accepted.
- R3: On activation, messages leave the head of the queue while header bytes (one byte for the default 8-bit identifier) plus `in_len` fit in the remaining data field, so a frame never carries more than `slot_bytes` bytes; a message that exactly fills the remaining space is sent. `in_len` must lie in 1..MAX_BYTES.
- R4: A message is never split across frames. Packing ends at the first head message that does not fit whole, even if a later, smaller message would fit.
- R5: Each message in the frame is sent as its identifier bytes (least significant byte first) followed by `in_len` payload bytes taken from `in_data`, starting with bits [7:0].
- R6: Messages left unsent remain queued and are sent on a later activation, in the same order.
- R7: An activation with an empty queue produces no frame bytes and still pulses `frame_done`.
- R8: `frame_done` is high for exactly one cycle, after the last byte of the frame.
- R9: `in_ready` is low while the queue holds DEPTH messages, while a frame is being built, and while `slot_go` is high. A message offered while `in_ready` is low is not stored and never appears in a frame.
- R10: After reset the queue is empty, `in_ready` is high, and `out_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Enqueue request |
| in_ready | output | 1 | Enqueue accepted when high together with `in_valid` |
| in_prio | input | PRIO_W | Urgency level, larger value is more urgent |
| in_len | input | LEN_W | Payload length in bytes, 1..MAX_BYTES |
| in_id | input | ID_W | Message identifier sent as the header |
| in_data | input | 8*MAX_BYTES | Payload, byte 0 in bits [7:0] |
| slot_go | input | 1 | One-cycle slot activation strobe |
| slot_bytes | input | SLOT_W | Data-field length of the activated slot in bytes |
| out_valid | output | 1 | `out_data` carries a frame byte this cycle |
| out_data | output | 8 | Frame byte |
| frame_done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
Directed patterns come first. Out-of-order urgencies show whether sorting is by urgency or by arrival, and equal urgencies show whether ties keep arrival order. A large head message placed ahead of a small one separates a packer that stops at the first misfit from one that skips ahead. Slot lengths equal to and one below the exact total of two messages expose off-by-one errors in the fit test. A full queue and an empty activation cover the edge of storage. Random rounds then mix queue contents and slot lengths across many frames. Each frame's byte stream is compared with a bench model, so the carried-over residue from earlier rounds is checked as well.

// File: rtl/pfp_pkg.sv
// Shared types for the priority-ordered frame packer.
package pfp_pkg;
    typedef enum logic [1:0] {
        PK_IDLE   = 2'd0,
        PK_DECIDE = 2'd1,
        PK_SEND   = 2'd2
    } pk_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/pfp_msg_queue.sv
// Urgency-sorted message store.
// Keeps entries ordered: larger priority toward index 0, ties in arrival
// order. Assumes push and pop never occur in the same cycle (the top
// gates push with the builder's busy state).
module pfp_msg_queue #(
    parameter int DEPTH    = 8,
    parameter int PRIO_W   = 4,
    parameter int LEN_W    = 3,
    parameter int ID_W     = 8,
    parameter int DATA_W   = 32,
    parameter int MAX_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic              full_o,
    output logic              head_valid_o,
    output logic [LEN_W-1:0]  head_len_o,
    output logic [ID_W-1:0]   head_id_o,
    output logic [DATA_W-1:0] head_data_o
);
    localparam int ENT_W = PRIO_W + LEN_W + ID_W + DATA_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] ins_pos;
    logic [ENT_W-1:0] push_word;

    assign push_word = {prio_i, len_i, id_i, data_i};

    // Insertion point: number of stored entries with priority >= new one.
    always_comb begin
        ins_pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < count_q) && (ent_q[i][ENT_W-1 -: PRIO_W] >= prio_i))
                ins_pos = ins_pos + 1'b1;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (push_i)
            count_q <= count_q + 1'b1;
        else if (pop_i)
            count_q <= count_q - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [ENT_W-1:0] prev_w;
        logic [ENT_W-1:0] next_w;
        if (g == 0) begin : g_first
            assign prev_w = push_word;
        end else begin : g_rest
            assign prev_w = ent_q[g-1];
        end
        if (g == DEPTH - 1) begin : g_last
            assign next_w = ent_q[g];
        end else begin : g_inner
            assign next_w = ent_q[g+1];
        end

        // Entry update: insert/shift down on push, shift up on pop.
        always_ff @(posedge clk) begin
            if (push_i) begin
                if (CNT_W'(g) == ins_pos)
                    ent_q[g] <= push_word;
                else if (CNT_W'(g) > ins_pos)
                    ent_q[g] <= prev_w;
            end else if (pop_i) begin
                ent_q[g] <= next_w;
            end
        end

        if (g < DEPTH - 1) begin : g_chk
            AST_QUEUE_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
                (CNT_W'(g + 1) < count_q) |->
                (ent_q[g][ENT_W-1 -: PRIO_W] >= ent_q[g+1][ENT_W-1 -: PRIO_W])) // R1
                else $error("queue order broken");
        end
    end

    assign full_o       = (count_q == CNT_W'(DEPTH));
    assign head_valid_o = (count_q != '0);
    assign head_len_o   = ent_q[0][DATA_W+ID_W +: LEN_W];
    assign head_id_o    = ent_q[0][DATA_W +: ID_W];
    assign head_data_o  = ent_q[0][DATA_W-1:0];

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)) // R9
        else $error("push and pop together");

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> ((len_i != '0) && (len_i <= LEN_W'(MAX_BYTES)))) // R3
        else $error("illegal message length");

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i) // R9
        else $error("push into full queue");
endmodule

// File: rtl/pfp_frame_builder.sv
// Frame builder: on a slot strobe, streams head messages (header then
// payload) while each fits whole in the remaining data field.
// Assumes every message plus header is no larger than any slot length.
module pfp_frame_builder
    import pfp_pkg::*;
#(
    parameter int LEN_W     = 3,
    parameter int ID_W      = 8,
    parameter int MAX_BYTES = 4,
    parameter int SLOT_W    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_go_i,
    input  logic [SLOT_W-1:0]        slot_bytes_i,
    input  logic                     head_valid_i,
    input  logic [LEN_W-1:0]         head_len_i,
    input  logic [ID_W-1:0]          head_id_i,
    input  logic [8*MAX_BYTES-1:0]   head_data_i,
    output logic                     pop_o,
    output logic                     busy_o,
    output logic                     out_valid_o,
    output logic [BYTE_W-1:0]        out_data_o,
    output logic                     frame_done_o
);
    localparam int HDR    = ID_W / BYTE_W;
    localparam int NBYTES = HDR + MAX_BYTES;
    localparam int IDX_W  = $clog2(NBYTES);

    pk_state_e         state_q;
    logic [SLOT_W-1:0] rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic              done_q;
    logic [SLOT_W-1:0] need;
    logic              fits;
    logic              last_byte;
    logic [BYTE_W-1:0] byte_mux [NBYTES];

    for (genvar b = 0; b < HDR; b++) begin : g_hdr
        assign byte_mux[b] = head_id_i[BYTE_W*b +: BYTE_W];
    end
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_pay
        assign byte_mux[HDR+b] = head_data_i[BYTE_W*b +: BYTE_W];
    end

    assign need      = SLOT_W'(HDR) + SLOT_W'(head_len_i);
    assign fits      = head_valid_i && (need <= rem_q);
    assign last_byte = (idx_q == (IDX_W'(HDR) + IDX_W'(head_len_i) - 1'b1));

    // Packing sequencer: capture slot, decide per message, stream bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
            rem_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                PK_IDLE: begin
                    if (slot_go_i) begin
                        rem_q   <= slot_bytes_i;
                        state_q <= PK_DECIDE;
                    end
                end
                PK_DECIDE: begin
                    if (fits) begin
                        idx_q   <= '0;
                        state_q <= PK_SEND;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= PK_IDLE;
                    end
                end
                PK_SEND: begin
                    if (last_byte) begin
                        rem_q   <= rem_q - need;
                        state_q <= PK_DECIDE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= PK_IDLE;
            endcase
        end
    end

    assign pop_o        = (state_q == PK_SEND) && last_byte;
    assign busy_o       = (state_q != PK_IDLE);
    assign out_valid_o  = (state_q == PK_SEND);
    assign out_data_o   = byte_mux[idx_q];
    assign frame_done_o = done_q;

    // Checker state: bytes emitted in the current frame and its slot length.
    logic [SLOT_W-1:0] chk_sent_q;
    logic [SLOT_W-1:0] chk_cap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_sent_q <= '0;
            chk_cap_q  <= '0;
        end else if ((state_q == PK_IDLE) && slot_go_i) begin
            chk_sent_q <= '0;
            chk_cap_q  <= slot_bytes_i;
        end else if (out_valid_o) begin
            chk_sent_q <= chk_sent_q + 1'b1;
        end
    end

    AST_FRAME_WITHIN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (chk_sent_q < chk_cap_q)) // R3
        else $error("frame exceeds slot");

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o) // R8
        else $error("frame_done longer than one cycle");

    AST_DONE_NOT_STREAMING: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !out_valid_o) // R8
        else $error("frame_done during byte stream");

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PK_SEND) && $past(state_q == PK_SEND) && $past(!pop_o)) |->
        ($stable(head_id_i) && $stable(head_len_i))) // R4
        else $error("head changed inside a message");

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PK_DECIDE) && !head_valid_i) |=> (frame_done_o && !out_valid_o)) // R7
        else $error("empty queue did not close frame");
endmodule

// File: rtl/prio_frame_packer.sv
// Priority-ordered dynamic frame packer top.
// Accepts messages into an urgency-sorted queue and, on each slot
// strobe, packs whole messages from the head into a byte stream.
// Assumes HDR + in_len <= slot_bytes for every message and slot.
module prio_frame_packer
    import pfp_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int PRIO_W    = 4,
    parameter int ID_W      = 8,
    parameter int MAX_BYTES = 4,
    parameter int SLOT_W    = 6,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int DATA_W   = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PRIO_W-1:0] in_prio,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [ID_W-1:0]   in_id,
    input  logic [DATA_W-1:0] in_data,
    input  logic              slot_go,
    input  logic [SLOT_W-1:0] slot_bytes,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              frame_done
);
    logic              q_full;
    logic              q_head_valid;
    logic [LEN_W-1:0]  q_head_len;
    logic [ID_W-1:0]   q_head_id;
    logic [DATA_W-1:0] q_head_data;
    logic              b_pop;
    logic              b_busy;
    logic              push;

    // Enqueue gate: only while idle, not full and no strobe this cycle.
    assign in_ready = !q_full && !b_busy && !slot_go;
    assign push     = in_valid && in_ready;

    pfp_msg_queue #(
        .DEPTH     (DEPTH),
        .PRIO_W    (PRIO_W),
        .LEN_W     (LEN_W),
        .ID_W      (ID_W),
        .DATA_W    (DATA_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .prio_i       (in_prio),
        .len_i        (in_len),
        .id_i         (in_id),
        .data_i       (in_data),
        .pop_i        (b_pop),
        .full_o       (q_full),
        .head_valid_o (q_head_valid),
        .head_len_o   (q_head_len),
        .head_id_o    (q_head_id),
        .head_data_o  (q_head_data)
    );

    pfp_frame_builder #(
        .LEN_W     (LEN_W),
        .ID_W      (ID_W),
        .MAX_BYTES (MAX_BYTES),
        .SLOT_W    (SLOT_W)
    ) u_builder (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_go_i    (slot_go),
        .slot_bytes_i (slot_bytes),
        .head_valid_i (q_head_valid),
        .head_len_i   (q_head_len),
        .head_id_i    (q_head_id),
        .head_data_i  (q_head_data),
        .pop_o        (b_pop),
        .busy_o       (b_busy),
        .out_valid_o  (out_valid),
        .out_data_o   (out_data),
        .frame_done_o (frame_done)
    );

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (b_busy || slot_go) |-> !in_ready) // R9
        else $error("enqueue open during frame");
endmodule

// File: tb/prio_frame_packer_bench.sv
// Bench: directed corners plus seeded random rounds, frames compared
// byte-for-byte with a bench-side queue model.
module prio_frame_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int PRIO_W     = 4;
    localparam int ID_W       = 8;
    localparam int MAX_BYTES  = 4;
    localparam int SLOT_W     = 6;
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int DATA_W     = 8 * MAX_BYTES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [PRIO_W-1:0] in_prio = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [ID_W-1:0]   in_id = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              slot_go = 1'b0;
    logic [SLOT_W-1:0] slot_bytes = '0;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              frame_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Model queue
    int m_cnt = 0;
    int m_prio [DEPTH];
    int m_len  [DEPTH];
    int m_id   [DEPTH];
    logic [DATA_W-1:0] m_data [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_frame_packer #(
        .DEPTH(DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W),
        .MAX_BYTES(MAX_BYTES), .SLOT_W(SLOT_W)
    ) u_prio_frame_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_prio(in_prio), .in_len(in_len), .in_id(in_id), .in_data(in_data),
        .slot_go(slot_go), .slot_bytes(slot_bytes), .out_valid(out_valid),
        .out_data(out_data), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Model insertion: after all entries of equal or higher priority.
    task automatic model_insert(input int p, input int l, input int id,
                                input logic [DATA_W-1:0] d);
        int pos = 0;
        while (pos < m_cnt && m_prio[pos] >= p) pos++;
        for (int i = m_cnt; i > pos; i--) begin
            m_prio[i] = m_prio[i-1]; m_len[i] = m_len[i-1];
            m_id[i] = m_id[i-1];     m_data[i] = m_data[i-1];
        end
        m_prio[pos] = p; m_len[pos] = l; m_id[pos] = id; m_data[pos] = d;
        m_cnt++;
    endtask

    task automatic model_pop();
        for (int i = 0; i < m_cnt - 1; i++) begin
            m_prio[i] = m_prio[i+1]; m_len[i] = m_len[i+1];
            m_id[i] = m_id[i+1];     m_data[i] = m_data[i+1];
        end
        m_cnt--;
    endtask

    task automatic enqueue(input int p, input int l, input int id,
                           input logic [DATA_W-1:0] d);
        bit exp_ready;
        @(negedge clk);
        in_valid = 1'b1;
        in_prio  = PRIO_W'(p);
        in_len   = LEN_W'(l);
        in_id    = ID_W'(id);
        in_data  = d;
        exp_ready = (m_cnt < DEPTH);
        #1;
        check(in_ready == exp_ready, "R9", "in_ready on offer", in_ready, exp_ready);
        @(negedge clk);
        in_valid = 1'b0;
        if (exp_ready) model_insert(p, l, id, d);
    endtask

    // Activate a slot, collect the frame, compare with the model.
    task automatic activate(input int slot, input string req);
        byte unsigned got [64];
        byte unsigned exp [64];
        int n_got = 0;
        int n_exp = 0;
        int rem;
        bit seen_done = 1'b0;
        @(negedge clk);
        slot_go = 1'b1;
        slot_bytes = SLOT_W'(slot);
        @(negedge clk);
        slot_go = 1'b0;
        for (int t = 0; t < 200; t++) begin
            if (out_valid && n_got < 64) begin
                got[n_got] = out_data;
                n_got++;
            end
            if (frame_done) begin
                seen_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check(seen_done, "R8", "frame_done seen", seen_done, 1);
        @(negedge clk);
        check(frame_done == 1'b0, "R8", "frame_done one cycle", frame_done, 0);
        rem = slot;
        while (m_cnt > 0 && (1 + m_len[0]) <= rem) begin
            exp[n_exp] = byte'(m_id[0]); n_exp++;
            for (int b = 0; b < m_len[0]; b++) begin
                exp[n_exp] = m_data[0][8*b +: 8];
                n_exp++;
            end
            rem -= 1 + m_len[0];
            model_pop();
        end
        check(n_got == n_exp, req, "frame length", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(got[i] == exp[i], req, $sformatf("frame byte %0d", i), got[i], exp[i]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1337);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(frame_done == 1'b0, "R10", "frame_done after reset", frame_done, 0);

        // R7: empty activation
        activate(20, "R7");

        // R1: urgency order against arrival order; R5 byte layout
        enqueue(2, 3, 8'h21, 32'hA3A2A1A0);
        enqueue(7, 2, 8'h71, 32'hB3B2B1B0);
        enqueue(5, 4, 8'h51, 32'hC3C2C1C0);
        activate(40, "R1");

        // R2: equal urgency keeps arrival order; R5 payload low byte first
        enqueue(3, 1, 8'h31, 32'h000000D0);
        enqueue(3, 2, 8'h32, 32'h0000E1E0);
        enqueue(3, 4, 8'h33, 32'hF3F2F1F0);
        enqueue(9, 1, 8'h91, 32'h00000099);
        activate(40, "R2");

        // R4: head misfit blocks a smaller later message; R6 carry-over
        enqueue(5, 2, 8'h0A, 32'h00001112);
        enqueue(4, 4, 8'h0B, 32'h21222324);
        enqueue(3, 1, 8'h0C, 32'h00000031);
        activate(6, "R4");
        activate(6, "R6");
        activate(6, "R6");

        // R3: exact fit and one byte short
        enqueue(6, 4, 8'h61, 32'h44434241);
        enqueue(6, 2, 8'h62, 32'h00005251);
        activate(7, "R3");
        activate(8, "R3");
        enqueue(6, 4, 8'h63, 32'h54535251);
        enqueue(6, 2, 8'h64, 32'h00006261);
        activate(8, "R3");

        // R9: fill the queue, offer one more, then drain
        for (int k = 0; k < DEPTH + 1; k++)
            enqueue(k % 4, 1 + (k % MAX_BYTES), 8'h80 + k, 32'h01020304 * (k + 1));
        activate(63, "R9");
        activate(63, "R7");

        // Random rounds mixing queue contents and slot lengths
        for (int r = 0; r < 400; r++) begin
            int nq = $urandom_range(0, 3);
            for (int k = 0; k < nq; k++) begin
                if (m_cnt < DEPTH)
                    enqueue($urandom_range(0, 15), $urandom_range(1, MAX_BYTES),
                            $urandom_range(0, 255), $urandom);
            end
            activate($urandom_range(1 + MAX_BYTES, 20), "R3");
        end
        activate(63, "R6");
        finish_run();
    end
endmodule